// File: doc/BRIEF.md
# Input Blanking Output Controller

This block sits between the sampling and conversion path of an image-sensor front end and its 10-bit digital output. It runs on the pixel clock. An active-low blanking strobe shields the front end from large input transients. While the strobe is low, the sampling enable to the front end is withdrawn. In the same period, the converter word on the output is replaced by a programmable blanking value. When the strobe is released, converter data appears on the output again at the next pixel clock.

The block also watches how the blanking strobe is placed relative to the active-low optical-black clamp strobe. The minimum spacing depends on which strobe comes first. When blanking precedes the clamp, the clamp must not start until at least four pixel clocks after blanking ends. When blanking follows the clamp, blanking must not start until the optical-black pixel count plus four pixel clocks after the clamp starts. The optical-black pixel count is a configuration input. If either rule is broken, a sticky error flag is set. Only reset or a clear pulse removes it.

Top module: `blank_out_ctrl`

## Requirements
- R1: `sample_en` takes, on each rising clock edge, the value of `blank_n` sampled at that edge: it is 0 in the cycle after an edge with `blank_n` low, and 1 after an edge with `blank_n` high.
- R2: After an edge at which `blank_n` is sampled low, `data_out` equals the `blank_value` sampled at that edge.
- R3: After an edge at which `blank_n` is sampled high, `data_out` equals the `adc_data` sampled at that edge. Converter data therefore returns one clock after blanking is released.
- R4: A synchronous reset (`rst_n` low at an edge) sets `data_out` to 0, `sample_en` to 1 and `spacing_err` to 0.
- R5: An edge event is a change of a strobe between two consecutive sampled values. Take a clamp fall (`clamp_n` 1 then 0) sampled d edges after the most recent blanking rise (`blank_n` 0 then 1), with d = 0 meaning the same edge. If d < 4, `spacing_err` is 1 after that edge.
- R6: A clamp fall sampled at an edge where `blank_n` is also sampled low sets `spacing_err`.
- R7: Take a blanking fall sampled d edges after the most recent clamp fall, with d = 0 meaning the same edge. If d < `ob_pixels` + 4, `spacing_err` is set after that edge. If d = `ob_pixels` + 4 or more, it is not set.
- R8: A rule is checked only against an edge of the other strobe that has not yet been checked. A blanking fall with no clamp fall since reset, or since the previous blanking fall, sets no error. A clamp fall with no blanking rise since the previous clamp fall sets no error by R5.
- R9: The gap counters saturate at 2047 edges and never wrap. With `ob_pixels` = 1023, a blanking fall 3000 edges after a clamp fall sets no error.
- R10: `spacing_err` stays 1 until an edge with `err_clear` high clears it. A violation sampled at the same edge as `err_clear` leaves `spacing_err` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blank_n | input | 1 | Blanking strobe, active low |
| clamp_n | input | 1 | Optical-black clamp strobe, active low |
| adc_data | input | 10 | Conversion result from the converter |
| blank_value | input | 10 | Programmed word shown during blanking |
| ob_pixels | input | 10 | Optical-black pixels per line |
| err_clear | input | 1 | Clears the spacing error flag |
| sample_en | output | 1 | Correlated-sampling enable to the front end |
| data_out | output | 10 | Output data word |
| spacing_err | output | 1 | Sticky strobe-spacing violation flag |

## Verification
The clear pulse and a fresh spacing violation can land on the same pixel clock edge. When they do, the flag must stay set and the new error must not be lost. The bench provokes this by raising `err_clear` in the same cycle that it drops `clamp_n` one edge after a blanking release. It expects `spacing_err` to read 1 afterwards, and to read 0 after a later clear that has no violation beside it. The spacing rules themselves are swept over every gap from zero to past the threshold, for several optical-black counts. Each gap's expected flag is computed from the comparison d < threshold.

// File: rtl/blank_pkg.sv
// Package: shared constants and the strobe event record for the blanking controller.
// Assumes both strobes are already synchronous to the pixel clock.
package blank_pkg;
    localparam int PRE_GAP    = 4;  // pixels from blanking release to clamp start
    localparam int POST_EXTRA = 4;  // pixels added to the optical-black count

    typedef struct packed {
        logic blank_fall;
        logic blank_rise;
        logic clamp_fall;
        logic blank_low;
    } strobe_ev_t;
endpackage

// File: rtl/strobe_edges.sv
// Module: strobe_edges
// Keeps the previous sampled level of both strobes and reports the edge
// events seen at the current clock edge. Assumes strobes are synchronous.
module strobe_edges
    import blank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       blank_n,
    input  logic       clamp_n,
    output strobe_ev_t ev
);
    logic blank_prev;
    logic clamp_prev;

    // Hold last sampled strobe levels; idle level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blank_prev <= 1'b1;
            clamp_prev <= 1'b1;
        end else begin
            blank_prev <= blank_n;
            clamp_prev <= clamp_n;
        end
    end

    // Decode the events present at this edge.
    always_comb begin
        ev.blank_fall = blank_prev & ~blank_n;
        ev.blank_rise = ~blank_prev & blank_n;
        ev.clamp_fall = clamp_prev & ~clamp_n;
        ev.blank_low  = ~blank_n;
    end
endmodule

// File: rtl/gap_counter.sv
// Module: gap_counter
// Counts clock edges since the last restart. It reads d at the d-th edge
// after the restart edge and saturates at its all-ones value.
module gap_counter #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    output logic [W-1:0] gap
);
    localparam logic [W-1:0] TOP = '1;

    // Restart to one, otherwise count up until saturated.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap <= '0;
        else if (restart)
            gap <= W'(1);
        else if (gap != TOP)
            gap <= gap + 1'b1;
    end

    assert_sat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(restart) && $past(gap) == TOP) |-> gap == TOP);

    assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(restart)) |-> gap >= $past(gap));
endmodule

// File: rtl/spacing_check.sv
// Module: spacing_check
// Applies both order-dependent spacing rules between the blanking and clamp
// strobes and keeps a sticky error flag. Each rule is armed by the first
// strobe's edge and disarmed when checked.
module spacing_check
    import blank_pkg::*;
#(
    parameter int OBC_W = 10,
    parameter int CNT_W = OBC_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  strobe_ev_t       ev,
    input  logic [OBC_W-1:0] ob_pixels,
    input  logic             err_clear,
    output logic             spacing_err
);
    logic [CNT_W-1:0] since_rise;
    logic [CNT_W-1:0] since_clamp;
    logic             armed_pre;
    logic             armed_post;
    logic             viol_pre;
    logic             viol_overlap;
    logic             viol_post;
    logic             viol;
    logic [CNT_W-1:0] post_limit;

    gap_counter #(.W(CNT_W)) u_rise_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ev.blank_rise),
        .gap     (since_rise)
    );

    gap_counter #(.W(CNT_W)) u_clamp_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ev.clamp_fall),
        .gap     (since_clamp)
    );

    // Evaluate the rules for the events at this edge.
    always_comb begin
        post_limit   = CNT_W'(ob_pixels) + CNT_W'(POST_EXTRA);
        viol_pre     = ev.clamp_fall &
                       (ev.blank_rise | (armed_pre & (since_rise < CNT_W'(PRE_GAP))));
        viol_overlap = ev.clamp_fall & ev.blank_low;
        viol_post    = ev.blank_fall &
                       (ev.clamp_fall | (armed_post & (since_clamp < post_limit)));
        viol         = viol_pre | viol_overlap | viol_post;
    end

    // Arm each rule on its leading edge and disarm it once checked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_pre  <= 1'b0;
            armed_post <= 1'b0;
        end else begin
            if (ev.clamp_fall)
                armed_pre <= 1'b0;
            else if (ev.blank_rise)
                armed_pre <= 1'b1;
            if (ev.blank_fall)
                armed_post <= 1'b0;
            else if (ev.clamp_fall)
                armed_post <= 1'b1;
        end
    end

    // Sticky flag: a new violation wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            spacing_err <= 1'b0;
        else if (viol)
            spacing_err <= 1'b1;
        else if (err_clear)
            spacing_err <= 1'b0;
    end

    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(spacing_err) && !$past(err_clear)) |-> spacing_err);

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(err_clear) && !$past(viol)) |-> !spacing_err);

    assert_pre_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ev.clamp_fall) && $past(ev.blank_rise)) |-> spacing_err);
endmodule

// File: rtl/output_stage.sv
// Module: output_stage
// Registers the sampling enable and selects the output word: the blanking
// value while the blanking strobe is sampled low, the converter word otherwise.
module output_stage #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blank_n,
    input  logic [DATA_W-1:0] adc_data,
    input  logic [DATA_W-1:0] blank_value,
    output logic              sample_en,
    output logic [DATA_W-1:0] data_out
);
    // Register the enable and the substituted or passed output word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_en <= 1'b1;
            data_out  <= '0;
        end else begin
            sample_en <= blank_n;
            data_out  <= blank_n ? adc_data : blank_value;
        end
    end

    assert_subst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(blank_n)) |-> data_out == $past(blank_value));

    assert_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(blank_n)) |-> data_out == $past(adc_data));
endmodule

// File: rtl/blank_out_ctrl.sv
// Module: blank_out_ctrl (top)
// Input blanking output controller: gates the sampling enable and
// substitutes the output word during blanking, and flags strobe-spacing
// violations. Assumes all inputs are synchronous to the pixel clock.
module blank_out_ctrl #(
    parameter int DATA_W = 10,
    parameter int OBC_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blank_n,
    input  logic              clamp_n,
    input  logic [DATA_W-1:0] adc_data,
    input  logic [DATA_W-1:0] blank_value,
    input  logic [OBC_W-1:0]  ob_pixels,
    input  logic              err_clear,
    output logic              sample_en,
    output logic [DATA_W-1:0] data_out,
    output logic              spacing_err
);
    import blank_pkg::*;

    localparam int CNT_W = OBC_W + 1;

    strobe_ev_t ev;

    strobe_edges u_edges (
        .clk     (clk),
        .rst_n   (rst_n),
        .blank_n (blank_n),
        .clamp_n (clamp_n),
        .ev      (ev)
    );

    spacing_check #(.OBC_W(OBC_W), .CNT_W(CNT_W)) u_check (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev          (ev),
        .ob_pixels   (ob_pixels),
        .err_clear   (err_clear),
        .spacing_err (spacing_err)
    );

    output_stage #(.DATA_W(DATA_W)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .blank_n     (blank_n),
        .adc_data    (adc_data),
        .blank_value (blank_value),
        .sample_en   (sample_en),
        .data_out    (data_out)
    );

    assert_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !sample_en) |-> data_out == $past(blank_value));

    assert_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ev.clamp_fall) && !$past(blank_n)) |-> spacing_err);
endmodule

// File: tb/tb_blank_out_ctrl.sv
module tb_blank_out_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       blank_n;
    logic       clamp_n;
    logic [9:0] adc_data;
    logic [9:0] blank_value;
    logic [9:0] ob_pixels;
    logic       err_clear;
    logic       sample_en;
    logic [9:0] data_out;
    logic       spacing_err;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blank_out_ctrl dut (
        .clk(clk), .rst_n(rst_n), .blank_n(blank_n), .clamp_n(clamp_n),
        .adc_data(adc_data), .blank_value(blank_value), .ob_pixels(ob_pixels),
        .err_clear(err_clear), .sample_en(sample_en), .data_out(data_out),
        .spacing_err(spacing_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; blank_n = 1'b1; clamp_n = 1'b1; err_clear = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    initial begin
        rst_n = 1'b0; blank_n = 1'b1; clamp_n = 1'b1; err_clear = 1'b0;
        adc_data = 10'h155; blank_value = 10'h2AA; ob_pixels = 10'd0;
        @(negedge clk);
        tick(); tick();
        chk("R4 data_out", data_out, 0);
        chk("R4 sample_en", sample_en, 1);
        chk("R4 spacing_err", spacing_err, 0);
        rst_n = 1'b1;
        tick();

        // R1 R2 R3: blanking pattern sweep with changing data words
        ob_pixels = 10'd1023;
        for (int i = 0; i < 48; i++) begin
            logic b;
            b = ((i / 3) % 2 == 0) ^ (i % 7 == 0);
            blank_n     = b;
            adc_data    = 10'((i * 37 + 5) % 1024);
            blank_value = 10'((i * 91 + 300) % 1024);
            tick();
            chk("R1 sample_en", sample_en, int'(b));
            if (b) chk("R3 pass data", data_out, (i * 37 + 5) % 1024);
            else   chk("R2 subst data", data_out, (i * 91 + 300) % 1024);
        end
        blank_n = 1'b1;
        adc_data = 10'd777;
        tick();
        chk("R3 release next clock", data_out, 777);

        // R5: clamp fall d edges after blanking release
        for (int d = 0; d < 8; d++) begin
            do_reset();
            blank_n = 1'b0; tick(); tick();
            blank_n = 1'b1;
            repeat (d) tick();
            clamp_n = 1'b0; tick();
            chk("R5 pre-clamp gap", spacing_err, int'(d < 4));
        end

        // R6: clamp fall while blanking low
        do_reset();
        blank_n = 1'b0; tick(); tick();
        clamp_n = 1'b0; tick();
        chk("R6 clamp inside blanking", spacing_err, 1);

        // R7: blanking fall d edges after clamp fall, several ob counts
        for (int k = 0; k < 3; k++) begin
            int ob;
            ob = (k == 0) ? 0 : (k == 1) ? 1 : 5;
            for (int d = 0; d <= ob + 6; d++) begin
                do_reset();
                ob_pixels = 10'(ob);
                clamp_n = 1'b0;
                repeat (d) tick();
                blank_n = 1'b0; tick();
                chk("R7 post-clamp gap", spacing_err, int'(d < ob + 4));
            end
        end

        // R8: no check without an unchecked edge of the other strobe
        do_reset();
        ob_pixels = 10'd0;
        blank_n = 1'b0; tick(); tick();
        chk("R8 blank fall unarmed", spacing_err, 0);
        blank_n = 1'b1; repeat (10) tick();
        clamp_n = 1'b0; tick(); tick();
        clamp_n = 1'b1; repeat (20) tick();
        blank_n = 1'b0; tick();
        chk("R8 blank fall far after clamp", spacing_err, 0);
        blank_n = 1'b1; tick();
        blank_n = 1'b0; tick();
        chk("R8 second blank fall disarmed", spacing_err, 0);
        blank_n = 1'b1; repeat (10) tick();
        clamp_n = 1'b0; tick(); clamp_n = 1'b1; tick();
        clamp_n = 1'b0; tick();
        chk("R8 second clamp fall disarmed", spacing_err, 0);

        // R9: saturation boundary and long gap with the largest ob count
        do_reset();
        ob_pixels = 10'd1023;
        clamp_n = 1'b0;
        repeat (1026) tick();
        blank_n = 1'b0; tick();
        chk("R9 gap 1026 below limit", spacing_err, 1);
        do_reset();
        ob_pixels = 10'd1023;
        clamp_n = 1'b0;
        repeat (1027) tick();
        blank_n = 1'b0; tick();
        chk("R9 gap 1027 at limit", spacing_err, 0);
        do_reset();
        ob_pixels = 10'd1023;
        clamp_n = 1'b0;
        repeat (3000) tick();
        blank_n = 1'b0; tick();
        chk("R9 saturated long gap", spacing_err, 0);

        // R10: sticky flag, clear, and clear coinciding with a violation
        do_reset();
        blank_n = 1'b0; tick(); tick();
        blank_n = 1'b1; tick();
        clamp_n = 1'b0; err_clear = 1'b1; tick();
        err_clear = 1'b0;
        chk("R10 violation beats clear", spacing_err, 1);
        clamp_n = 1'b1; repeat (12) tick();
        chk("R10 flag sticky", spacing_err, 1);
        err_clear = 1'b1; tick();
        err_clear = 1'b0;
        chk("R10 clear alone", spacing_err, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule